// File: doc/BRIEF.md
# ADC Conversion-Start Trigger Controller

This block decides when an analog-to-digital converter begins a conversion. It issues a single-cycle start pulse, and the source of that pulse is picked by a 2-bit mode value written over a control strobe. The sources are a software write strobe, the falling edges of a free-running pacer timer, the falling edges of an asynchronous external trigger pin, and a second pacer whose contribution is gated by the external pin.

Two of the modes are gated. In the pre-trigger mode the second pacer starts enabled, and the first external falling edge disables it. In the post-trigger mode the second pacer starts disabled, and the first external falling edge enables it. The block drives a gate-enable output toward that pacer. Writing a mode value again, including the same value, restores the gate to the initial state of that mode. The pacer timers and the converter sit outside the block.

Top module: `adc_trig_top`

## Requirements
- R1: After reset, `adcStart` and `pacer1Gate` are 0 and the mode is the general mode (code 00). A software strobe given straight after reset therefore produces a start.
- R2: In mode 00 (general), two events each produce a start pulse in the cycle after the event edge: a `swTrigWr` strobe, or a falling edge of `pacer0` (the input is high in one cycle and low in the next).
- R3: In mode 01 (external clock), the external input passes through a two-flop synchronizer and then a falling-edge detector. A high-to-low change first applied before clock edge k gives `adcStart` high after edge k+2. This is exactly one pulse, however long the input stays low.
- R4: In mode 10 (pre-trigger), `pacer1Gate` is 1 in the cycle after the mode write. While the gate is 1, each `pacer1` falling edge produces a start. The first detected external falling edge clears the gate, on the same clock edge at which that edge would raise a start in mode 01. After that, `pacer1` produces no starts.
- R5: In mode 11 (post-trigger), `pacer1Gate` is 0 after the mode write and `pacer1` edges produce no starts. The first detected external falling edge sets the gate, and from then on each `pacer1` falling edge produces a start.
- R6: In modes 10 and 11, only the first detected external falling edge after a mode write changes the gate. Later edges leave `pacer1Gate` unchanged until the next mode write.
- R7: Every `modeWr` loads `modeIn` and cancels any gating already done. The gate becomes 1 if the written code is 10 and 0 otherwise, even when the code equals the current mode.
- R8: `adcStart` never stays high for two consecutive cycles. Simultaneous qualifying events merge into one pulse. An event whose edge falls in the cycle in which `adcStart` is already high is dropped.
- R9: Some sources are ignored depending on the mode. In modes 00 and 01, `pacer1Gate` is 0 and `pacer1` has no effect. `swTrigWr` and `pacer0` act only in mode 00. The external input makes starts only in mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 2 | Mode code to load (00 general, 01 external clock, 10 pre-trigger, 11 post-trigger) |
| modeWr | input | 1 | Load strobe for `modeIn` |
| swTrigWr | input | 1 | Software trigger strobe |
| pacer0 | input | 1 | Output of the free-running pacer timer |
| pacer1 | input | 1 | Output of the gated pacer timer |
| extTrigIn | input | 1 | Asynchronous external trigger input |
| adcStart | output | 1 | One-cycle conversion start pulse |
| pacer1Gate | output | 1 | Gate enable for the second pacer |

## Verification
Directed sequences check each mode on its own:
- a software strobe merged with a `pacer0` edge, and back-to-back strobes, which separate merging from dropping;
- an external low held for many cycles, which shows that detection is on the edge and not on the level;
- repeated external edges in the gated modes, which show that the gate latches on the first edge and that a rewrite re-arms it.

Constrained-random traffic then mixes rare mode writes with:
- software strobes;
- pacer toggles;
- external pulses held at least three cycles.

Every cycle is compared against a cycle model. This random phase catches ordering faults that the directed cases cannot reach, such as a pacer edge landing on the same clock as a gate change or a mode write.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    MODE_GENERAL = 2'b00,
    MODE_EXTCLK  = 2'b01,
    MODE_PRE     = 2'b10,
    MODE_POST    = 2'b11
  } trig_mode_e;

  // Source enables handed from control to datapath
  typedef struct packed {
    logic swEn;
    logic pac0En;
    logic extEn;
    logic pac1En;
  } trig_en_t;

  localparam int NUM_PACERS = 2;

endpackage

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       modeWr,
  input  logic       extFall,
  output trig_en_t   srcEn,
  output logic       gateOn,
  output trig_mode_e modeQ
);

  logic fired;
  logic gatedMode;

  assign gatedMode = (modeQ == MODE_PRE) || (modeQ == MODE_POST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_GENERAL;
      gateOn <= 1'b0;
      fired  <= 1'b0;
    end else if (modeWr) begin
      modeQ  <= trig_mode_e'(modeIn);
      gateOn <= (modeIn == MODE_PRE);
      fired  <= 1'b0;
    end else if (extFall && !fired && gatedMode) begin
      fired  <= 1'b1;
      gateOn <= (modeQ == MODE_POST);
    end
  end

  always_comb begin
    srcEn.swEn   = (modeQ == MODE_GENERAL);
    srcEn.pac0En = (modeQ == MODE_GENERAL);
    srcEn.extEn  = (modeQ == MODE_EXTCLK);
    srcEn.pac1En = gatedMode && gateOn;
  end

endmodule

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PACERS      = NUM_PACERS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTrigIn,
  input  logic [PACERS-1:0] pacerIn,
  input  logic              swTrigWr,
  input  trig_en_t          srcEn,
  output logic              extFall,
  output logic              adcStart
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  // Synchronizer plus one history stage for edge detection; idle level is high
  logic [PIPE_W-1:0] extPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPipe <= '1;
    else       extPipe <= {extPipe[PIPE_W-2:0], extTrigIn};
  end

  assign extFall = extPipe[PIPE_W-1] & ~extPipe[PIPE_W-2];

  logic [PACERS-1:0] pacPrev;
  logic [PACERS-1:0] pacFall;

  for (genvar gi = 0; gi < PACERS; gi++) begin : g_pacEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pacPrev[gi] <= 1'b0;
      else       pacPrev[gi] <= pacerIn[gi];
    end
    assign pacFall[gi] = pacPrev[gi] & ~pacerIn[gi];
  end

  logic startEv;

  always_comb begin
    startEv = (srcEn.swEn   & swTrigWr)
            | (srcEn.pac0En & pacFall[0])
            | (srcEn.extEn  & extFall)
            | (srcEn.pac1En & pacFall[PACERS-1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) adcStart <= 1'b0;
    else       adcStart <= startEv & ~adcStart;
  end

endmodule

// File: rtl/adc_trig_top.sv
module adc_trig_top
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       modeWr,
  input  logic       swTrigWr,
  input  logic       pacer0,
  input  logic       pacer1,
  input  logic       extTrigIn,
  output logic       adcStart,
  output logic       pacer1Gate
);

  trig_en_t   srcEn;
  trig_mode_e modeQ;
  logic       extFall;

  adc_trig_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeIn  (modeIn),
    .modeWr  (modeWr),
    .extFall (extFall),
    .srcEn   (srcEn),
    .gateOn  (pacer1Gate),
    .modeQ   (modeQ)
  );

  adc_trig_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .PACERS      (NUM_PACERS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extTrigIn (extTrigIn),
    .pacerIn   ({pacer1, pacer0}),
    .swTrigWr  (swTrigWr),
    .srcEn     (srcEn),
    .extFall   (extFall),
    .adcStart  (adcStart)
  );

endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeIn,
  input logic       modeWr,
  input logic       swTrigWr,
  input logic [1:0] curMode,
  input logic       adcStart,
  input logic       pacer1Gate
);

  // R2
  sw_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swTrigWr && curMode == 2'b00 && !adcStart) |=> adcStart);

  // R4
  pre_gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWr && curMode == 2'b10 && !pacer1Gate) |=> !pacer1Gate);

  // R5
  post_gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWr && curMode == 2'b11 && pacer1Gate) |=> pacer1Gate);

  // R7
  mode_write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (pacer1Gate == ($past(modeIn) == 2'b10)));

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R9
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode[1] == 1'b0) |-> !pacer1Gate);

endmodule

bind adc_trig_top adc_trig_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeIn     (modeIn),
  .modeWr     (modeWr),
  .swTrigWr   (swTrigWr),
  .curMode    (modeQ),
  .adcStart   (adcStart),
  .pacer1Gate (pacer1Gate)
);

// File: tb/tb_adc_trig_top.sv
`timescale 1ns/1ps
module tb_adc_trig_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic       modeWr = 1'b0;
  logic       swTrigWr = 1'b0;
  logic       pacer0 = 1'b1;
  logic       pacer1 = 1'b1;
  logic       extTrigIn = 1'b1;
  logic       adcStart;
  logic       pacer1Gate;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_trig_top dut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeWr(modeWr),
    .swTrigWr(swTrigWr), .pacer0(pacer0), .pacer1(pacer1),
    .extTrigIn(extTrigIn), .adcStart(adcStart), .pacer1Gate(pacer1Gate)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements
  logic [1:0] mMode;
  logic       mGate, mFired, mStart, mP0, mP1;
  logic [2:0] mPipe;

  function automatic logic modelEvent(logic [1:0] md, logic sw, logic p0f,
                                      logic xf, logic p1f, logic gate);
    case (md)
      2'b00:   return sw | p0f;
      2'b01:   return xf;
      default: return p1f & gate;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 2'b00; mGate = 1'b0; mFired = 1'b0; mStart = 1'b0;
      mPipe = 3'b111; mP0 = 1'b0; mP1 = 1'b0;
    end else begin
      logic xf, p0f, p1f, nStart;
      xf  = mPipe[2] & ~mPipe[1];
      p0f = mP0 & ~pacer0;
      p1f = mP1 & ~pacer1;
      nStart = modelEvent(mMode, swTrigWr, p0f, xf, p1f, mGate) & ~mStart;
      if (modeWr) begin
        mMode = modeIn; mGate = (modeIn == 2'b10); mFired = 1'b0;
      end else if (xf && !mFired && mMode[1]) begin
        mFired = 1'b1; mGate = (mMode == 2'b11);
      end
      mStart = nStart;
      mPipe  = {mPipe[1:0], extTrigIn};
      mP0 = pacer0; mP1 = pacer1;
    end
  end

  function automatic string modeTag(logic [1:0] md);
    case (md)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      chk(modeTag(mMode), adcStart, mStart);
      chk(mMode[1] ? "R6" : "R9", pacer1Gate, mGate);
    end
  end

  task automatic writeMode(logic [1:0] m);
    modeIn = m; modeWr = 1'b1;
    @(negedge clk);
    modeWr = 1'b0;
  endtask

  task automatic pulsePac(int idx, output int n);
    n = 0;
    if (idx == 0) pacer0 = 1'b0; else pacer1 = 1'b0;
    repeat (3) begin @(negedge clk); n += adcStart; end
    if (idx == 0) pacer0 = 1'b1; else pacer1 = 1'b1;
    @(negedge clk); n += adcStart;
  endtask

  task automatic extPulse(output int n);
    n = 0;
    extTrigIn = 1'b0;
    repeat (5) begin @(negedge clk); n += adcStart; end
    extTrigIn = 1'b1;
    repeat (4) begin @(negedge clk); n += adcStart; end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int hold;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", adcStart, 1'b0);
    chk("R1", pacer1Gate, 1'b0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    repeat (2) @(negedge clk);

    // R1: mode resets to general, so a software strobe starts a conversion
    swTrigWr = 1'b1; @(negedge clk); swTrigWr = 1'b0;
    chk("R1", adcStart, 1'b1);
    @(negedge clk); chk("R8", adcStart, 1'b0);

    // R8: strobe and pacer0 edge in the same cycle merge
    swTrigWr = 1'b1; pacer0 = 1'b0; @(negedge clk); swTrigWr = 1'b0;
    chk("R8", adcStart, 1'b1);
    @(negedge clk); chk("R8", adcStart, 1'b0);
    pacer0 = 1'b1; repeat (2) @(negedge clk);

    // R8: back-to-back strobes, second one dropped
    swTrigWr = 1'b1; @(negedge clk); chk("R8", adcStart, 1'b1);
    @(negedge clk); swTrigWr = 1'b0; chk("R8", adcStart, 1'b0);
    @(negedge clk);

    // R2 / R9 in general mode
    pulsePac(0, n); chk("R2", n == 1, 1'b1);
    pulsePac(1, n); chk("R9", n == 0, 1'b1);
    extPulse(n);    chk("R9", n == 0, 1'b1);

    // R3: external clock mode latency and level insensitivity
    writeMode(2'b01);
    extTrigIn = 1'b0;
    @(negedge clk); chk("R3", adcStart, 1'b0);
    @(negedge clk); chk("R3", adcStart, 1'b0);
    @(negedge clk); chk("R3", adcStart, 1'b1);
    n = 0; repeat (10) begin @(negedge clk); n += adcStart; end
    chk("R3", n == 0, 1'b1);
    extTrigIn = 1'b1; repeat (3) @(negedge clk);
    swTrigWr = 1'b1; @(negedge clk); swTrigWr = 1'b0;
    @(negedge clk); chk("R9", adcStart, 1'b0);
    pulsePac(0, n); chk("R9", n == 0, 1'b1);
    chk("R9", pacer1Gate, 1'b0);

    // R4: pre-trigger
    writeMode(2'b10); chk("R4", pacer1Gate, 1'b1);
    pulsePac(1, n); chk("R4", n == 1, 1'b1);
    extPulse(n); chk("R4", pacer1Gate, 1'b0);
    pulsePac(1, n); chk("R4", n == 0, 1'b1);
    extPulse(n); chk("R6", pacer1Gate, 1'b0);
    writeMode(2'b10); chk("R7", pacer1Gate, 1'b1);
    pulsePac(1, n); chk("R7", n == 1, 1'b1);

    // R5: post-trigger
    writeMode(2'b11); chk("R5", pacer1Gate, 1'b0);
    pulsePac(1, n); chk("R5", n == 0, 1'b1);
    extPulse(n); chk("R5", pacer1Gate, 1'b1);
    pulsePac(1, n); chk("R5", n == 1, 1'b1);
    extPulse(n); chk("R6", pacer1Gate, 1'b1);
    writeMode(2'b11); chk("R7", pacer1Gate, 1'b0);

    // Random phase, compared every cycle against the model
    hold = 4;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      modeWr   = ($urandom % 40) == 0;
      modeIn   = 2'($urandom % 4);
      swTrigWr = ($urandom % 8) == 0;
      if (($urandom % 5) == 0) pacer0 = ~pacer0;
      if (($urandom % 5) == 0) pacer1 = ~pacer1;
      hold--;
      if (hold <= 0) begin
        extTrigIn = ~extTrigIn;
        hold = 3 + int'($urandom % 6);
      end
    end
    @(negedge clk);
    modeWr = 1'b0; swTrigWr = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule